// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block turns one input clock into two slower clocks. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter or one sixth of the input rate. Each output has its own static select input. A single phase counter drives both outputs. The counter's frame length is the least common multiple of all the ratios, so the outputs always begin their high phase together at the start of a frame. Wherever their rising edges coincide, they coincide on the same input edge.

The shared enable is sampled on the falling input edge. Starting and stopping happen only on a frame boundary, where every output is low, so a shortened pulse cannot appear. A select change waits for that same boundary. An active-high asynchronous master reset clears the counter and drives both outputs low. After release, every instance restarts from the same phase, so several instances stay in lockstep.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With sel_a_i = 0 output A divides by 2. With sel_a_i = 1 it divides by 4. Inside a frame of 12 input cycles numbered from 0, A is high in cycle k when (k mod ratio) < ratio/2.
- R2: With sel_b_i = 0 output B divides by 4. With sel_b_i = 1 it divides by 6. The pattern rule is the same as in R1.
- R3: Every high pulse on an output lasts exactly half its ratio in input cycles. With the divide-by-6 ratio an output is high for 3 cycles and then low for 3 cycles.
- R4: In frame cycle 0 both outputs are high, and both rise on the same input rising edge.
- R5: The value of en_i at an input falling edge decides whether the divider runs from the next rising edge. A pulse on en_i that covers no falling edge has no effect.
- R6: When the enabled divider starts from idle, both outputs rise on the first rising edge after the enable is captured. That first high pulse has full length.
- R7: Clearing the enable stops the divider only at the end of the current frame. Until then the outputs keep their pattern, and after the stop both are low.
- R8: While rst_i is high, both outputs are low at once, without waiting for a clock edge. After release, the divider restarts in frame cycle 0.
- R9: A select change takes effect only at a frame boundary. During the rest of the current frame the output keeps its old pattern.
- R10: While the divider is idle, both outputs stay low whatever the selects do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Master reset, active high, asynchronous |
| en_i | input | 1 | Shared run enable, sampled on the falling clock edge |
| sel_a_i | input | 1 | Ratio select for output A (0: /2, 1: /4) |
| sel_b_i | input | 1 | Ratio select for output B (0: /4, 1: /6) |
| clk_a_o | output | 1 | Divided clock A |
| clk_b_o | output | 1 | Divided clock B |

## Verification
The assertions check on every cycle that both outputs are high at frame start, that both outputs are low while idle, and that every pulse has half-ratio length. They also check that run state and the select latch change only at frame boundaries, and that the enable flop tracks en_i at falling edges. Some behaviour shows only in the bench's scenarios: the exact output pattern for each ratio pair, a select change taking hold only at the next frame, the late stop after disable, an enable glitch that misses the falling edge, and the outputs dropping mid-cycle on reset. The bench follows these with a cycle model and directed timing.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;

   typedef enum logic {
      RATIO_LO = 1'b0,
      RATIO_HI = 1'b1
   } ratio_sel_e;

   function automatic int unsigned gcd_u(input int unsigned x, input int unsigned y);
      int unsigned a;
      int unsigned b;
      int unsigned t;
      a = x;
      b = y;
      while (b != 0) begin
         t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   function automatic int unsigned lcm_u(input int unsigned x, input int unsigned y);
      return (x / gcd_u(x, y)) * y;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic bit ratio_ok(input int unsigned v);
      return (v >= 2) && ((v % 2) == 0);
   endfunction

endpackage

// File: rtl/dcd_enable_capture.sv
module dcd_enable_capture (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   output logic en_q_o
);

   always_ff @(negedge clk_i or posedge rst_i) begin
      if (rst_i) en_q_o <= 1'b0;
      else       en_q_o <= en_i;
   end

   assert_fall_capture_R5: assert property (@(negedge clk_i) disable iff (rst_i)
      $past(!rst_i) |-> (en_q_o == $past(en_i)));

endmodule

// File: rtl/dcd_frame_ctrl.sv
module dcd_frame_ctrl #(
   parameter int unsigned FRAME = 12,
   parameter int unsigned PH_W  = 4,
   parameter int unsigned N_OUT = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_q_i,
   input  logic [N_OUT-1:0] sel_i,
   output logic             run_n_o,
   output logic [PH_W-1:0]  ph_n_o,
   output logic [N_OUT-1:0] sel_n_o,
   output logic             run_q_o,
   output logic [PH_W-1:0]  ph_q_o,
   output logic [N_OUT-1:0] sel_q_o
);

   localparam logic [PH_W-1:0] LAST = PH_W'(FRAME - 1);

   if (FRAME < 2) begin : g_bad_frame
      $error("dcd_frame_ctrl: FRAME must be at least 2");
   end
   if ((1 << PH_W) < FRAME) begin : g_bad_width
      $error("dcd_frame_ctrl: PH_W too narrow for FRAME");
   end

   logic boundary;

   assign boundary = !run_q_o || (ph_q_o == LAST);

   always_comb begin
      if (boundary) begin
         run_n_o = en_q_i;
         ph_n_o  = '0;
         sel_n_o = sel_i;
      end else begin
         run_n_o = run_q_o;
         ph_n_o  = ph_q_o + PH_W'(1);
         sel_n_o = sel_q_o;
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         run_q_o <= 1'b0;
         ph_q_o  <= '0;
         sel_q_o <= '0;
      end else begin
         run_q_o <= run_n_o;
         ph_q_o  <= ph_n_o;
         sel_q_o <= sel_n_o;
      end
   end

   assert_run_at_boundary_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_q_o != $past(run_q_o)) |-> (!$past(run_q_o) || ($past(ph_q_o) == LAST)));

   assert_sel_at_boundary_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_q_o != $past(sel_q_o)) |-> (!$past(run_q_o) || ($past(ph_q_o) == LAST)));

   assert_phase_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q_o <= LAST);

   assert_idle_phase_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_q_o |-> (ph_q_o == '0));

endmodule

// File: rtl/dcd_tap.sv
module dcd_tap
   import dual_div_pkg::*;
#(
   parameter int unsigned DIV_LO = 2,
   parameter int unsigned DIV_HI = 4,
   parameter int unsigned PH_W   = 4
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            run_n_i,
   input  logic [PH_W-1:0] ph_n_i,
   input  logic            sel_n_i,
   input  logic            sel_cur_i,
   output logic            clk_o
);

   localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int unsigned CW      = $clog2(DIV_MAX) + 1;
   localparam logic [CW-1:0] HALF_LO = CW'(DIV_LO / 2);
   localparam logic [CW-1:0] HALF_HI = CW'(DIV_HI / 2);

   if (!ratio_ok(DIV_LO) || !ratio_ok(DIV_HI)) begin : g_bad_ratio
      $error("dcd_tap: ratios must be even and at least 2");
   end

   logic [1:0]    hi_vec;
   logic          hi_sel;
   logic [CW-1:0] hcnt;

   for (genvar k = 0; k < 2; k++) begin : g_ratio
      localparam int unsigned R = (k == 0) ? DIV_LO : DIV_HI;
      if (is_pow2(R)) begin : g_pow2
         assign hi_vec[k] = ~ph_n_i[$clog2(R)-1];
      end else begin : g_mod
         localparam logic [PH_W-1:0] RW = PH_W'(R);
         localparam logic [PH_W-1:0] HW = PH_W'(R / 2);
         assign hi_vec[k] = ((ph_n_i % RW) < HW);
      end
   end

   assign hi_sel = (ratio_sel_e'(sel_n_i) == RATIO_HI) ? hi_vec[1] : hi_vec[0];

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) clk_o <= 1'b0;
      else       clk_o <= run_n_i & hi_sel;
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)            hcnt <= '0;
      else if (!clk_o)      hcnt <= '0;
      else if (hcnt != '1)  hcnt <= hcnt + CW'(1);
   end

   assert_half_duty_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(clk_o) |-> (hcnt == (sel_cur_i ? HALF_HI : HALF_LO)));

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
   import dual_div_pkg::*;
#(
   parameter int unsigned A_DIV_LO = 2,
   parameter int unsigned A_DIV_HI = 4,
   parameter int unsigned B_DIV_LO = 4,
   parameter int unsigned B_DIV_HI = 6
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic sel_a_i,
   input  logic sel_b_i,
   output logic clk_a_o,
   output logic clk_b_o
);

   localparam int unsigned N_OUT = 2;
   localparam int unsigned FRAME = lcm_u(lcm_u(A_DIV_LO, A_DIV_HI), lcm_u(B_DIV_LO, B_DIV_HI));
   localparam int unsigned PH_W  = $clog2(FRAME);

   if (!ratio_ok(A_DIV_LO) || !ratio_ok(A_DIV_HI) ||
       !ratio_ok(B_DIV_LO) || !ratio_ok(B_DIV_HI)) begin : g_bad_cfg
      $error("dual_ratio_clkdiv: every ratio must be even and at least 2");
   end

   logic             en_q;
   logic             run_n;
   logic             run_q;
   logic [PH_W-1:0]  ph_n;
   logic [PH_W-1:0]  ph_q;
   logic [N_OUT-1:0] sel_in;
   logic [N_OUT-1:0] sel_n;
   logic [N_OUT-1:0] sel_q;
   logic [N_OUT-1:0] clk_vec;

   assign sel_in = {sel_b_i, sel_a_i};

   dcd_enable_capture u_en (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .en_q_o (en_q)
   );

   dcd_frame_ctrl #(
      .FRAME (FRAME),
      .PH_W  (PH_W),
      .N_OUT (N_OUT)
   ) u_ctrl (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_q_i  (en_q),
      .sel_i   (sel_in),
      .run_n_o (run_n),
      .ph_n_o  (ph_n),
      .sel_n_o (sel_n),
      .run_q_o (run_q),
      .ph_q_o  (ph_q),
      .sel_q_o (sel_q)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_tap
      localparam int unsigned LO = (i == 0) ? A_DIV_LO : B_DIV_LO;
      localparam int unsigned HI = (i == 0) ? A_DIV_HI : B_DIV_HI;
      dcd_tap #(
         .DIV_LO (LO),
         .DIV_HI (HI),
         .PH_W   (PH_W)
      ) u_tap (
         .clk_i     (clk_i),
         .rst_i     (rst_i),
         .run_n_i   (run_n),
         .ph_n_i    (ph_n),
         .sel_n_i   (sel_n[i]),
         .sel_cur_i (sel_q[i]),
         .clk_o     (clk_vec[i])
      );
   end

   assign clk_a_o = clk_vec[0];
   assign clk_b_o = clk_vec[1];

   assert_frame_align_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_q && (ph_q == '0)) |-> (clk_a_o && clk_b_o));

   assert_full_first_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(run_q) |-> (clk_a_o && clk_b_o));

   assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_q |-> (!clk_a_o && !clk_b_o));

endmodule

// File: tb/tb_dual_ratio_clkdiv.sv
module tb_dual_ratio_clkdiv;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic sel_a = 1'b0;
   logic sel_b = 1'b0;
   logic clk_a;
   logic clk_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_ratio_clkdiv dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .en_i    (en),
      .sel_a_i (sel_a),
      .sel_b_i (sel_b),
      .clk_a_o (clk_a),
      .clk_b_o (clk_b)
   );

   // cycle model built from the requirements
   logic m_en;
   logic m_run;
   int   m_cnt;
   logic m_sa;
   logic m_sb;

   function automatic logic pat(input int k, input int ratio);
      return (k % ratio) < (ratio / 2);
   endfunction

   always @(negedge clk or posedge rst) begin
      if (rst) m_en <= 1'b0;
      else     m_en <= en;
   end

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_run <= 1'b0; m_cnt <= 0; m_sa <= 1'b0; m_sb <= 1'b0;
      end else if (!m_run || m_cnt == 11) begin
         m_run <= m_en; m_cnt <= 0; m_sa <= sel_a; m_sb <= sel_b;
      end else begin
         m_cnt <= m_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle scoreboard
   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk("R1 pattern A", clk_a, m_run & pat(m_cnt, m_sa ? 4 : 2));
         chk("R2 pattern B", clk_b, m_run & pat(m_cnt, m_sb ? 6 : 4));
      end
   end

   task automatic step();
      @(posedge clk);
      #3;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic run_len(input bit use_b, input logic lvl, output int n);
      n = 0;
      while (((use_b ? clk_b : clk_a) == lvl) && n < 50) begin
         n++;
         step();
      end
   endtask

   initial begin
      int hcount;
      int lcount;
      void'($urandom(32'd20240611));
      rst = 1'b1;
      steps(3);
      chk("R8 reset A low", clk_a, 1'b0);
      chk("R8 reset B low", clk_b, 1'b0);
      rst = 1'b0;
      sel_a = 1'b1; sel_b = 1'b1; en = 1'b1;
      step();                                   // frame cycle 0
      chk("R6 first A high", clk_a, 1'b1);
      chk("R4 start B high", clk_b, 1'b1);
      steps(2);                                 // cycle 2
      chk("R1 /4 A low at 2", clk_a, 1'b0);
      chk("R2 /6 B high at 2", clk_b, 1'b1);
      steps(4);                                 // cycle 6
      chk("R1 /4 A low at 6", clk_a, 1'b0);
      chk("R2 /6 B high at 6", clk_b, 1'b1);
      steps(6);                                 // next cycle 0
      chk("R4 frame A high", clk_a, 1'b1);
      chk("R4 frame B high", clk_b, 1'b1);
      run_len(1'b1, 1'b1, hcount);              // ends at cycle 3
      run_len(1'b1, 1'b0, lcount);              // ends at cycle 6
      chk("R3 /6 high is 3", hcount == 3, 1'b1);
      chk("R3 /6 low is 3", lcount == 3, 1'b1);
      steps(6);                                 // cycle 0
      sel_a = 1'b0;
      step();                                   // cycle 1
      chk("R9 old /4 kept", clk_a, 1'b1);
      steps(2);                                 // cycle 3
      chk("R9 old /4 kept late", clk_a, 1'b0);
      steps(9);                                 // cycle 0
      chk("R9 new frame A high", clk_a, 1'b1);
      step();                                   // cycle 1
      chk("R1 /2 A low", clk_a, 1'b0);
      step();                                   // cycle 2
      chk("R1 /2 A high", clk_a, 1'b1);
      en = 1'b0;
      steps(2);                                 // cycle 4
      chk("R7 still running A", clk_a, 1'b1);
      steps(7);                                 // cycle 11
      chk("R7 end of frame A", clk_a, 1'b0);
      step();
      chk("R7 stopped A", clk_a, 1'b0);
      chk("R7 stopped B", clk_b, 1'b0);
      for (int i = 0; i < 6; i++) begin
         sel_a = i[0]; sel_b = i[1];
         step();
         chk("R10 idle A", clk_a, 1'b0);
         chk("R10 idle B", clk_b, 1'b0);
      end
      sel_a = 1'b1; sel_b = 1'b1;
      #3 en = 1'b1;                             // after the falling edge
      @(posedge clk); #3 en = 1'b0;             // before the next falling edge
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R5 glitch ignored", clk_a | clk_b, 1'b0);
      end
      en = 1'b1;
      step();
      chk("R5 captured start A", clk_a, 1'b1);
      chk("R5 captured start B", clk_b, 1'b1);
      step();                                   // cycle 1
      #1 rst = 1'b1;
      #1;
      chk("R8 async A low", clk_a, 1'b0);
      chk("R8 async B low", clk_b, 1'b0);
      steps(2);
      rst = 1'b0;
      step();
      chk("R8 restart A high", clk_a, 1'b1);
      chk("R8 restart B high", clk_b, 1'b1);
      for (int i = 0; i < 400; i++) begin
         en    = ($urandom % 4) != 0;
         sel_a = $urandom % 2;
         sel_b = $urandom % 2;
         steps(1 + ($urandom % 10));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule